// File: doc/BRIEF.md
# Barrel Shifter with Carry-Out

This block is the operand shifter of a 32-bit RISC datapath. It is purely combinational. In one pass it applies one of five shift kinds to an operand: logical left, logical right, arithmetic right, rotate right, and a one-place rotate through the carry. It also returns the bit that left the word last. The flag logic downstream uses that bit as the shifter carry. The flag register, the ALU and the decoder sit outside the block.

The shift distance has two possible sources. One is a 5-bit field taken from the instruction. The other is the low byte of a register value. The two sources treat a distance of zero differently, and the register byte can ask for 32 places or more. A sixth kind turns the shifter into a constant builder. It takes an 8-bit value from the low byte of the operand and rotates it right by twice a 4-bit field, giving a 32-bit immediate and its carry.

Top module: `barrel_shift_unit`

## Requirements
- R1: Kind 0 (logical left) by n in 1..31 returns the operand moved up n places with zeros in the low n bits, and carry-out is operand bit 32-n. For example, 0xEF00DE12 by 8 gives 0x00DE1200 with carry 1.
- R2: Kind 1 (logical right) by n in 1..31 returns the operand moved down n places with zeros in the high n bits, and carry-out is operand bit n-1. For example, 0x0456123F by 5 gives 0x0022B091 with carry 1.
- R3: Kind 2 (arithmetic right) by n in 1..31 fills the high n bits with the original bit 31, and carry-out is operand bit n-1. For example, 0xEF00DE12 by 4 gives 0xFEF00DE1 with carry 0.
- R4: Kind 3 (rotate right) by n that is not a multiple of 32 puts operand bit n-1 into result bit 31 and wraps every bit around, and carry-out equals result bit 31. For example, 0x0456123F by 28 gives 0x456123F0. A register distance that is a nonzero multiple of 32 returns the operand with carry equal to bit 31.
- R5: Kind 4 (rotate through carry) returns {carry_in, operand[31:1]} with carry-out equal to operand bit 0, and it ignores both distance inputs.
- R6: With amt_from_reg=1 and reg_amt=0, kinds 0 to 3 return the operand unchanged with carry-out equal to carry_in.
- R7: With amt_from_reg=1, a distance of 32 gives zero for kinds 0 and 1, with carry equal to operand bit 0 for kind 0 and operand bit 31 for kind 1. A distance above 32 gives zero with carry 0 for both. For kind 2, any distance of 32 or more gives 32 copies of bit 31, and the carry is also bit 31.
- R8: With amt_from_reg=0 and imm_amt=0, kinds 0 and 3 pass the operand through with carry equal to carry_in, and kinds 1 and 2 shift by 32 under the rules of R7.
- R9: Kind 5 returns operand[7:0] rotated right by 2*rot_field. Carry-out is carry_in when rot_field=0 and result bit 31 otherwise. Operand bits 31:8 and the distance inputs have no effect.
- R10: Kinds 6 and 7 return the operand unchanged with carry-out equal to carry_in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| operand | input | 32 | Value to shift; its low byte is the seed in kind 5 |
| kind | input | 3 | Shift kind code (see requirements) |
| imm_amt | input | 5 | Distance taken from the instruction |
| reg_amt | input | 8 | Distance taken from a register's low byte |
| amt_from_reg | input | 1 | 1 selects reg_amt, 0 selects imm_amt |
| rot_field | input | 4 | Half the rotation applied in kind 5 |
| carry_in | input | 1 | Current carry flag |
| result | output | 32 | Shifted value |
| carry_out | output | 1 | Shifter carry for the flag logic |

## Verification
The hardest cases to reach are the edges of the distance range. Register distances of exactly 32, just past 32, and large values such as 255 sit in the same 5-bit residue as ordinary distances. An immediate field of zero means three different things depending on the kind. The bench reaches these by sweeping reg_amt through 0..40 and then 63, 128 and 255, and by driving imm_amt=0 under every kind. It uses operands whose bit 0 and bit 31 differ, and runs each case with both carry_in values. That way a carry taken from the wrong end, or a carry_in leaking through where it should not, changes the value the bench sees.

// File: rtl/bshift_pkg.sv
package bshift_pkg;
   typedef enum logic [2:0] {
      SK_LSL   = 3'd0,
      SK_LSR   = 3'd1,
      SK_ASR   = 3'd2,
      SK_ROR   = 3'd3,
      SK_RRX   = 3'd4,
      SK_CONST = 3'd5
   } shift_kind_e;

   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction
endpackage

// File: rtl/bshift_rotator.sv
module bshift_rotator #(
   parameter int WIDTH  = 32,
   parameter bit STAGED = 1'b1,
   localparam int LOG   = $clog2(WIDTH)
) (
   input  logic [WIDTH-1:0] din,
   input  logic [LOG-1:0]   amt,
   output logic [WIDTH-1:0] dout
);
   generate
      if (STAGED) begin : g_staged
         logic [WIDTH-1:0] stg [0:LOG];
         assign stg[0] = din;
         for (genvar s = 0; s < LOG; s++) begin : g_stage
            localparam int STEP = 1 << s;
            assign stg[s+1] = amt[s] ? {stg[s][STEP-1:0], stg[s][WIDTH-1:STEP]}
                                     : stg[s];
         end
         assign dout = stg[LOG];
      end else begin : g_flat
         logic [2*WIDTH-1:0] dbl;
         assign dbl  = {din, din} >> amt;
         assign dout = dbl[WIDTH-1:0];
      end
   endgenerate
endmodule

// File: rtl/bshift_amount.sv
module bshift_amount
   import bshift_pkg::*;
#(
   parameter int WIDTH  = 32,
   parameter int IMM_AW = 5,
   parameter int REG_AW = 8,
   localparam int LOG   = $clog2(WIDTH)
) (
   input  logic [2:0]        kind,
   input  logic [IMM_AW-1:0] imm_amt,
   input  logic [REG_AW-1:0] reg_amt,
   input  logic              from_reg,
   output logic [LOG-1:0]    k,
   output logic              none,
   output logic              full,
   output logic              over
);
   localparam logic [REG_AW-1:0] W_N = REG_AW'(WIDTH);

   logic [REG_AW-1:0] n;
   logic              imm_full;
   logic              right_kind;

   assign n          = from_reg ? reg_amt : REG_AW'(imm_amt);
   assign right_kind = (kind == SK_LSR) || (kind == SK_ASR);
   assign imm_full   = !from_reg && (imm_amt == '0) && right_kind;
   assign none       = (n == '0) && !imm_full;
   assign full       = imm_full || (n == W_N);
   assign over       = n > W_N;
   assign k          = n[LOG-1:0];
endmodule

// File: rtl/bshift_core.sv
module bshift_core
   import bshift_pkg::*;
#(
   parameter int WIDTH  = 32,
   parameter bit STAGED = 1'b1,
   localparam int LOG   = $clog2(WIDTH)
) (
   input  logic [WIDTH-1:0] op,
   input  logic [2:0]       kind,
   input  logic [LOG-1:0]   k,
   input  logic             none,
   input  logic             full,
   input  logic             over,
   input  logic             cin,
   output logic [WIDTH-1:0] res,
   output logic             cout
);
   logic [LOG-1:0]   neg_k;
   logic [LOG-1:0]   km1;
   logic [LOG-1:0]   ramt;
   logic [WIDTH-1:0] rot;
   logic [WIDTH-1:0] lo_mask;
   logic [WIDTH-1:0] hi_mask;
   logic             sign;

   assign neg_k   = LOG'(0) - k;
   assign km1     = k - LOG'(1);
   assign ramt    = (kind == SK_LSL) ? neg_k : k;
   assign lo_mask = {WIDTH{1'b1}} >> k;
   assign hi_mask = {WIDTH{1'b1}} << k;
   assign sign    = op[WIDTH-1];

   bshift_rotator #(.WIDTH(WIDTH), .STAGED(STAGED)) u_rot (
      .din (op),
      .amt (ramt),
      .dout(rot)
   );

   always_comb begin
      res  = op;
      cout = cin;
      unique case (kind)
         SK_LSL: begin
            if (none) begin
               res = op; cout = cin;
            end else if (full) begin
               res = '0; cout = op[0];
            end else if (over) begin
               res = '0; cout = 1'b0;
            end else begin
               res = rot & hi_mask; cout = op[neg_k];
            end
         end
         SK_LSR: begin
            if (none) begin
               res = op; cout = cin;
            end else if (full) begin
               res = '0; cout = sign;
            end else if (over) begin
               res = '0; cout = 1'b0;
            end else begin
               res = rot & lo_mask; cout = op[km1];
            end
         end
         SK_ASR: begin
            if (none) begin
               res = op; cout = cin;
            end else if (full || over) begin
               res = {WIDTH{sign}}; cout = sign;
            end else begin
               res = (rot & lo_mask) | (~lo_mask & {WIDTH{sign}});
               cout = op[km1];
            end
         end
         SK_ROR: begin
            if (none) begin
               res = op; cout = cin;
            end else if (k == '0) begin
               res = op; cout = sign;
            end else begin
               res = rot; cout = rot[WIDTH-1];
            end
         end
         SK_RRX: begin
            res  = {cin, op[WIDTH-1:1]};
            cout = op[0];
         end
         default: begin
            res = op; cout = cin;
         end
      endcase
   end
endmodule

// File: rtl/bshift_const.sv
module bshift_const #(
   parameter int WIDTH  = 32,
   parameter int IMM_W  = 8,
   parameter int ROT_W  = 4,
   parameter bit STAGED = 1'b1,
   localparam int LOG   = $clog2(WIDTH)
) (
   input  logic [IMM_W-1:0] seed,
   input  logic [ROT_W-1:0] rot,
   input  logic             cin,
   output logic [WIDTH-1:0] value,
   output logic             cout
);
   logic [WIDTH-1:0] ext;
   logic [LOG-1:0]   amt;

   assign ext = {{(WIDTH-IMM_W){1'b0}}, seed};
   assign amt = LOG'({rot, 1'b0});

   bshift_rotator #(.WIDTH(WIDTH), .STAGED(STAGED)) u_rot (
      .din (ext),
      .amt (amt),
      .dout(value)
   );

   assign cout = (rot == '0) ? cin : value[WIDTH-1];
endmodule

// File: rtl/barrel_shift_unit.sv
module barrel_shift_unit
   import bshift_pkg::*;
#(
   parameter int WIDTH  = 32,
   parameter int IMM_AW = 5,
   parameter int REG_AW = 8,
   parameter int IMM_W  = 8,
   parameter int ROT_W  = 4,
   parameter bit STAGED = 1'b1
) (
   input  logic [WIDTH-1:0]  operand,
   input  logic [2:0]        kind,
   input  logic [IMM_AW-1:0] imm_amt,
   input  logic [REG_AW-1:0] reg_amt,
   input  logic              amt_from_reg,
   input  logic [ROT_W-1:0]  rot_field,
   input  logic              carry_in,
   output logic [WIDTH-1:0]  result,
   output logic              carry_out
);
   localparam int LOG = $clog2(WIDTH);

   generate
      if (!is_pow2(WIDTH) || WIDTH < 8) begin : g_bad_width
         $error("WIDTH must be a power of two of at least 8");
      end
      if (IMM_AW != LOG) begin : g_bad_imm
         $error("IMM_AW must equal log2(WIDTH)");
      end
      if (REG_AW <= LOG) begin : g_bad_reg
         $error("REG_AW must exceed log2(WIDTH)");
      end
      if (ROT_W + 1 > LOG || IMM_W > WIDTH) begin : g_bad_const
         $error("constant fields do not fit WIDTH");
      end
   endgenerate

   logic [LOG-1:0]   k;
   logic             none, full, over;
   logic [WIDTH-1:0] core_res, const_res;
   logic             core_c, const_c;

   bshift_amount #(.WIDTH(WIDTH), .IMM_AW(IMM_AW), .REG_AW(REG_AW)) u_amt (
      .kind    (kind),
      .imm_amt (imm_amt),
      .reg_amt (reg_amt),
      .from_reg(amt_from_reg),
      .k       (k),
      .none    (none),
      .full    (full),
      .over    (over)
   );

   bshift_core #(.WIDTH(WIDTH), .STAGED(STAGED)) u_core (
      .op  (operand),
      .kind(kind),
      .k   (k),
      .none(none),
      .full(full),
      .over(over),
      .cin (carry_in),
      .res (core_res),
      .cout(core_c)
   );

   bshift_const #(.WIDTH(WIDTH), .IMM_W(IMM_W), .ROT_W(ROT_W), .STAGED(STAGED)) u_const (
      .seed (operand[IMM_W-1:0]),
      .rot  (rot_field),
      .cin  (carry_in),
      .value(const_res),
      .cout (const_c)
   );

   assign result    = (kind == SK_CONST) ? const_res : core_res;
   assign carry_out = (kind == SK_CONST) ? const_c   : core_c;
endmodule

// File: rtl/barrel_shift_unit_chk.sv
module barrel_shift_unit_chk #(
   parameter int WIDTH  = 32,
   parameter int IMM_AW = 5,
   parameter int REG_AW = 8,
   parameter int IMM_W  = 8,
   parameter int ROT_W  = 4
) (
   input logic [WIDTH-1:0]  operand,
   input logic [2:0]        kind,
   input logic [IMM_AW-1:0] imm_amt,
   input logic [REG_AW-1:0] reg_amt,
   input logic              amt_from_reg,
   input logic [ROT_W-1:0]  rot_field,
   input logic              carry_in,
   input logic [WIDTH-1:0]  result,
   input logic              carry_out
);
   always_comb begin
      if (kind == 3'd0 && !amt_from_reg)
         assert_lsl_zero_fill_R1: assert ((result & ~({WIDTH{1'b1}} << imm_amt)) == '0)
            else $error("low bits not cleared after left shift");
      if (kind == 3'd2)
         assert_asr_sign_kept_R3: assert (result[WIDTH-1] == operand[WIDTH-1])
            else $error("arithmetic shift lost sign");
      if (kind == 3'd3)
         assert_ror_bits_kept_R4: assert ($countones(result) == $countones(operand))
            else $error("rotation changed bit count");
      if (kind == 3'd4)
         assert_rrx_through_carry_R5: assert (result[WIDTH-1] == carry_in && carry_out == operand[0])
            else $error("rotate through carry wrong");
      if (amt_from_reg && reg_amt == '0 && kind < 3'd4)
         assert_reg_zero_pass_R6: assert (result == operand && carry_out == carry_in)
            else $error("zero register distance altered data");
      if (kind == 3'd5)
         assert_const_bits_kept_R9: assert ($countones(result) == $countones(operand[IMM_W-1:0]))
            else $error("constant expansion changed bit count");
      if (kind == 3'd5 && rot_field == '0)
         assert_const_carry_hold_R9: assert (carry_out == carry_in)
            else $error("unrotated constant altered carry");
      if (kind[2:1] == 2'b11)
         assert_spare_pass_R10: assert (result == operand && carry_out == carry_in)
            else $error("spare code altered data");
   end
endmodule

bind barrel_shift_unit barrel_shift_unit_chk #(
   .WIDTH(WIDTH), .IMM_AW(IMM_AW), .REG_AW(REG_AW), .IMM_W(IMM_W), .ROT_W(ROT_W)
) u_chk (
   .operand     (operand),
   .kind        (kind),
   .imm_amt     (imm_amt),
   .reg_amt     (reg_amt),
   .amt_from_reg(amt_from_reg),
   .rot_field   (rot_field),
   .carry_in    (carry_in),
   .result      (result),
   .carry_out   (carry_out)
);

// File: tb/tb_barrel_shift_unit.sv
module tb_barrel_shift_unit;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 100000;

   logic        clk = 1'b0;
   logic [31:0] operand = '0;
   logic [2:0]  kind = '0;
   logic [4:0]  imm_amt = '0;
   logic [7:0]  reg_amt = '0;
   logic        amt_from_reg = 1'b0;
   logic [3:0]  rot_field = '0;
   logic        carry_in = 1'b0;
   logic [31:0] result;
   logic        carry_out;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   barrel_shift_unit dut (
      .operand(operand), .kind(kind), .imm_amt(imm_amt), .reg_amt(reg_amt),
      .amt_from_reg(amt_from_reg), .rot_field(rot_field), .carry_in(carry_in),
      .result(result), .carry_out(carry_out)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   // Reference: 64-bit windows, independent of the RTL structure
   function automatic logic [32:0] model(input int kd, input logic [31:0] op, input int n,
                                         input logic cin);
      logic [63:0] w;
      int          m;
      if (kd == 4) return {op[0], cin, op[31:1]};
      if (kd > 3 || n == 0) return {cin, op};
      m = (n > 63) ? 63 : n;
      case (kd)
         0: begin w = {32'b0, op} << m; return {w[32], w[31:0]}; end
         1: begin w = {op, 32'b0} >> m; return {w[31], w[63:32]}; end
         2: begin w = $unsigned($signed({op, 32'b0}) >>> m); return {w[31], w[63:32]}; end
         default: begin
            w = {op, op} >> (n % 32);
            return {w[31], w[31:0]};
         end
      endcase
   endfunction

   function automatic int eff_n(input int kd, input bit from_reg, input int imm, input int rg);
      if (from_reg) return rg;
      if (imm == 0 && (kd == 1 || kd == 2)) return 32;
      return imm;
   endfunction

   task automatic check(input string req, input logic [31:0] er, input logic ec);
      n_cmp++;
      if (result !== er || carry_out !== ec) begin
         n_bad++;
         $display("FAIL %s: kind=%0d op=%h got %h/c%0b expected %h/c%0b",
                  req, kind, operand, result, carry_out, er, ec);
      end
   endtask

   task automatic apply(input int kd, input logic [31:0] op, input bit fr, input int imm,
                        input int rg, input logic cin);
      kind = 3'(kd); operand = op; amt_from_reg = fr;
      imm_amt = 5'(imm); reg_amt = 8'(rg); carry_in = cin;
      #1;
   endtask

   task automatic t_idle();
      apply(0, 32'h0, 1'b0, 0, 0, 1'b1);
      check("R8 idle", 32'h0, 1'b1);
   endtask

   task automatic t_known();
      apply(0, 32'hEF00DE12, 1'b0, 8, 0, 1'b0); check("R1 known", 32'h00DE1200, 1'b1);
      apply(2, 32'hEF00DE12, 1'b1, 0, 4, 1'b1); check("R3 known", 32'hFEF00DE1, 1'b0);
      apply(3, 32'h0456123F, 1'b1, 0, 28, 1'b1); check("R4 known", 32'h456123F0, 1'b0);
      apply(1, 32'h0456123F, 1'b0, 5, 0, 1'b0); check("R2 known", 32'h0022B091, 1'b1);
   endtask

   task automatic t_imm_sweep();
      logic [31:0] ops [3] = '{32'h80000001, 32'h7FFFFFFE, 32'hC35A0F96};
      string tags [4] = '{"R1 imm", "R2 imm", "R3 imm", "R4 imm"};
      for (int kd = 0; kd < 4; kd++)
         for (int a = 0; a < 32; a++)
            for (int o = 0; o < 3; o++)
               for (int c = 0; c < 2; c++) begin
                  logic [32:0] e;
                  e = model(kd, ops[o], eff_n(kd, 1'b0, a, 0), c[0]);
                  apply(kd, ops[o], 1'b0, a, 0, c[0]);
                  check((a == 0) ? "R8 imm zero" : tags[kd], e[31:0], e[32]);
               end
   endtask

   task automatic t_reg_sweep();
      int extra [3] = '{63, 128, 255};
      logic [31:0] ops [2] = '{32'h80000001, 32'h6E5D4C3B};
      for (int i = 0; i < 44; i++) begin
         int amt;
         amt = (i < 41) ? i : extra[i-41];
         for (int kd = 0; kd < 4; kd++)
            for (int o = 0; o < 2; o++)
               for (int c = 0; c < 2; c++) begin
                  logic [32:0] e;
                  e = model(kd, ops[o], amt, c[0]);
                  apply(kd, ops[o], 1'b1, 7, amt, c[0]);
                  if (amt == 0) check("R6 reg zero", e[31:0], e[32]);
                  else if (amt >= 32) check("R7 reg wide", e[31:0], e[32]);
                  else check("R4 reg", e[31:0], e[32]);
               end
      end
   endtask

   task automatic t_rrx();
      apply(4, 32'h00000003, 1'b1, 9, 200, 1'b1); check("R5 rrx", 32'h80000001, 1'b1);
      apply(4, 32'hFFFFFFFE, 1'b0, 31, 0, 1'b0);  check("R5 rrx", 32'h7FFFFFFF, 1'b0);
   endtask

   task automatic t_const();
      for (int r = 0; r < 16; r++)
         for (int c = 0; c < 2; c++) begin
            logic [63:0] dd;
            logic [31:0] ev;
            dd = {2{24'h0, 8'hB7}} >> (2 * r);
            ev = dd[31:0];
            rot_field = 4'(r);
            apply(5, 32'hFFFFFFB7, 1'b1, 13, 99, c[0]);
            check("R9 const", ev, (r == 0) ? c[0] : ev[31]);
         end
      rot_field = 4'd4;
      apply(5, 32'h12345601, 1'b0, 0, 0, 1'b0);
      check("R9 const upper ignored", 32'h01000000, 1'b0);
   endtask

   task automatic t_spare();
      apply(6, 32'hA5A5F00F, 1'b1, 3, 17, 1'b1); check("R10 code6", 32'hA5A5F00F, 1'b1);
      apply(7, 32'h5A5A0FF0, 1'b0, 3, 17, 1'b0); check("R10 code7", 32'h5A5A0FF0, 1'b0);
   endtask

   initial begin
      int cyc = 0;
      while (!done) begin
         @(posedge clk);
         cyc++;
         if (cyc > WATCHDOG) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
         end
      end
   end

   initial begin
      #(CLK_PERIOD/4);
      t_idle();
      t_known();
      t_imm_sweep();
      t_reg_sweep();
      t_rrx();
      t_const();
      t_spare();
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule